// File: doc/BRIEF.md
# Programmable LED Status Driver

This block drives one network-activity indicator pin. A 32-bit control register holds an enable bit for each event or status input. The enabled inputs are ORed into a raw indicator value, which software reads back as a status bit. A pulse stretcher can hold the pin active after short events. A polarity bit chooses the pin's electrical mode: open-drain active-low or push-pull active-high. A disable bit forces the pin to its idle level.

The collision input is masked for a short window after each end-of-transmit strobe. This keeps the post-transmit heartbeat test from lighting the indicator. The length of that window is four microseconds, computed from a clock-frequency parameter. The stretch length is a cycle-count parameter.

Two small state machines do the work.

The stretcher has three states:
- `S_DARK`: nothing is pending.
- `S_LIT`: the raw value was true at the last edge.
- `S_HOLD`: a countdown is running.

Its transitions:
- Any state moves to `S_LIT` while raw is true.
- `S_LIT` moves to `S_HOLD` when raw falls with stretching on. It moves to `S_DARK` when stretching is off.
- `S_HOLD` moves to `S_DARK` when the count is spent or stretching is turned off.

The collision window has two states:
- `W_OPEN`: collisions pass through.
- `W_MASK`: collisions are masked.

Its transitions:
- `W_OPEN` moves to `W_MASK` on the transmit-done strobe.
- `W_MASK` reloads on a new strobe.
- `W_MASK` returns to `W_OPEN` when its count is spent.

Soft reset or stop sends both machines to `S_DARK` / `W_OPEN`.

Top module: `led_status_drv`

## Requirements
- R1: Hard reset sets the control register to 0x0000_0090: bit 7 (stretch enable) and bit 4 (transmit-activity enable) are 1 and all other writable bits are 0.
- R2: Read bit 15 equals the OR of `ev_in[i]` AND control bit i for i in 0..6, plus the terms of R3; an input whose enable bit is 0 has no effect on bit 15 or the pin.
- R3: Control bit 8 enables the term `link_pass AND fdx_on`; control bit 9 enables the term `mp_mode AND mp_hit`.
- R4: With bit 14 = 0 and bit 13 = 0, `led_o` is 0 and `led_oe` is 1 exactly while the indicator is active (open-drain, active low).
- R5: With bit 14 = 1 and bit 13 = 0, `led_oe` is 1 and `led_o` equals the indicator's active value (push-pull, active high).
- R6: With bit 13 = 1, `led_oe` is 0 when bit 14 = 0, and `led_oe` = 1 with `led_o` = 0 when bit 14 = 1.
- R7: Bit 15 reports the unstretched OR and does not depend on bit 14, bit 13 or stretching.
- R8: With bit 7 = 1, the indicator stays active for exactly STRETCH_CYC cycles after the last cycle on which the raw OR was true.
- R9: With bit 7 = 0, the indicator follows the raw OR in the same cycle and drops in the same cycle the raw OR falls.
- R10: `ev_in[0]` (collision) is ignored in the cycle `tx_done` is high and for the following CLK_MHZ*4 cycles; a new strobe restarts the window.
- R11: Writes to bits 31:16, 15 and 12:10 are ignored; those bits read as 0 (bit 15 reads status only).
- R12: Soft reset and stop leave the control bits unchanged; they clear the stretch countdown and the collision window at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, asynchronous, active low |
| srst_n | input | 1 | Soft reset, synchronous, active low |
| stop | input | 1 | Stop condition, clears timers only |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 32 | Control register write data |
| rd_data | output | 32 | Control register read data with status in bit 15 |
| ev_in | input | 7 | Event inputs; bit 0 collision, bit 4 transmit activity |
| tx_done | input | 1 | End-of-transmit strobe |
| link_pass | input | 1 | Link test passing |
| fdx_on | input | 1 | Full duplex enabled |
| mp_mode | input | 1 | Magic packet mode enabled |
| mp_hit | input | 1 | Magic packet detected |
| led_o | output | 1 | Indicator pin value |
| led_oe | output | 1 | Indicator pin output enable |

## Verification
Status bit 15 and the pin follow the inputs in the same cycle. A register write shows on the read port one edge after the strobe. Stretching holds the pin for STRETCH_CYC cycles after the last sampled edge with raw true. The collision mask covers the strobe cycle plus CLK_MHZ*4 more, and a stop or soft reset takes effect at the next edge. The bench drives inputs just after a falling edge and queues the expected values at that moment. Its monitor compares them one time unit later, well before the next rising edge, so every expected value is placed in the exact cycle counted from these latencies.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
    typedef enum logic [1:0] {S_DARK, S_LIT, S_HOLD} str_state_e;
    typedef enum logic {W_OPEN, W_MASK} win_state_e;

    localparam int NUM_EV   = 7;
    localparam int BIT_STAT = 15;
    localparam int BIT_POL  = 14;
    localparam int BIT_DIS  = 13;
    localparam int BIT_MPE  = 9;
    localparam int BIT_LFE  = 8;
    localparam int BIT_PSE  = 7;
    localparam int BIT_COL  = 0;

    localparam logic [31:0] CTRL_WMASK   = 32'h0000_63FF;
    localparam logic [31:0] CTRL_DEFAULT = 32'h0000_0090;
endpackage

// File: rtl/led_ctrl_reg.sv
module led_ctrl_reg
    import led_drv_pkg::*;
(
    input  logic        clk,
    input  logic        hrst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] ctrl_q
);
    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n)
            ctrl_q <= CTRL_DEFAULT;
        else if (wr_en)
            ctrl_q <= wr_data & CTRL_WMASK;
    end
endmodule

// File: rtl/led_sqe_window.sv
module led_sqe_window
    import led_drv_pkg::*;
#(
    parameter int WIN_CYC = 132
) (
    input  logic clk,
    input  logic hrst_n,
    input  logic clr,
    input  logic tx_done,
    output logic mask
);
    localparam int CW = $clog2(WIN_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(WIN_CYC - 1);

    win_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            W_OPEN: begin
                if (tx_done) begin
                    state_d = W_MASK;
                    cnt_d   = RELOAD;
                end
            end
            W_MASK: begin
                if (tx_done)
                    cnt_d = RELOAD;
                else if (cnt_q == '0)
                    state_d = W_OPEN;
                else
                    cnt_d = cnt_q - 1'b1;
            end
        endcase
        if (clr) begin
            state_d = W_OPEN;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            state_q <= W_OPEN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        mask = tx_done || (state_q == W_MASK);
    end
endmodule

// File: rtl/led_stretch.sv
module led_stretch
    import led_drv_pkg::*;
#(
    parameter int HOLD_CYC = 1650000
) (
    input  logic clk,
    input  logic hrst_n,
    input  logic clr,
    input  logic raw,
    input  logic pse,
    output logic active
);
    localparam int  CW   = $clog2(HOLD_CYC + 1);
    localparam bit  LONG = (HOLD_CYC >= 2);
    localparam logic [CW-1:0] RELOAD = LONG ? CW'(HOLD_CYC - 2) : '0;

    str_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_DARK: begin
                if (raw) state_d = S_LIT;
            end
            S_LIT: begin
                if (!raw) begin
                    if (pse && LONG) begin
                        state_d = S_HOLD;
                        cnt_d   = RELOAD;
                    end else begin
                        state_d = S_DARK;
                    end
                end
            end
            S_HOLD: begin
                if (raw)
                    state_d = S_LIT;
                else if (!pse || cnt_q == '0)
                    state_d = S_DARK;
                else
                    cnt_d = cnt_q - 1'b1;
            end
            default: state_d = S_DARK;
        endcase
        if (clr) begin
            state_d = S_DARK;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            state_q <= S_DARK;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active = raw || (pse && (state_q != S_DARK));
    end
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
    import led_drv_pkg::*;
#(
    parameter int CLK_MHZ     = 33,
    parameter int SQE_US      = 4,
    parameter int STRETCH_CYC = 1650000
) (
    input  logic        clk,
    input  logic        hrst_n,
    input  logic        srst_n,
    input  logic        stop,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic [6:0]  ev_in,
    input  logic        tx_done,
    input  logic        link_pass,
    input  logic        fdx_on,
    input  logic        mp_mode,
    input  logic        mp_hit,
    output logic        led_o,
    output logic        led_oe
);
    localparam int SQE_CYC = CLK_MHZ * SQE_US;

    logic [31:0]       ctrl_q;
    logic              clr, sqe_mask, raw_or, pin_active;
    logic [NUM_EV-1:0] ev_eff;

    assign clr = !srst_n || stop;

    led_ctrl_reg u_reg (
        .clk     (clk),
        .hrst_n  (hrst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q)
    );

    led_sqe_window #(.WIN_CYC(SQE_CYC)) u_win (
        .clk     (clk),
        .hrst_n  (hrst_n),
        .clr     (clr),
        .tx_done (tx_done),
        .mask    (sqe_mask)
    );

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        if (i == BIT_COL) begin : g_col
            assign ev_eff[i] = ev_in[i] && !sqe_mask && ctrl_q[i];
        end else begin : g_plain
            assign ev_eff[i] = ev_in[i] && ctrl_q[i];
        end
    end

    always_comb begin
        raw_or = (|ev_eff)
               || (ctrl_q[BIT_LFE] && link_pass && fdx_on)
               || (ctrl_q[BIT_MPE] && mp_mode && mp_hit);
    end

    led_stretch #(.HOLD_CYC(STRETCH_CYC)) u_str (
        .clk    (clk),
        .hrst_n (hrst_n),
        .clr    (clr),
        .raw    (raw_or),
        .pse    (ctrl_q[BIT_PSE]),
        .active (pin_active)
    );

    always_comb begin
        rd_data           = ctrl_q;
        rd_data[BIT_STAT] = raw_or;
    end

    always_comb begin
        unique case ({ctrl_q[BIT_DIS], ctrl_q[BIT_POL]})
            2'b00: begin led_o = 1'b0;       led_oe = pin_active; end
            2'b01: begin led_o = pin_active; led_oe = 1'b1;       end
            2'b10: begin led_o = 1'b0;       led_oe = 1'b0;       end
            2'b11: begin led_o = 1'b0;       led_oe = 1'b1;       end
        endcase
    end
endmodule

// File: rtl/led_status_chk.sv
module led_status_chk (
    input logic        clk,
    input logic        hrst_n,
    input logic        srst_n,
    input logic        stop,
    input logic        wr_en,
    input logic        tx_done,
    input logic [31:0] rd_data,
    input logic        led_o,
    input logic        led_oe,
    input logic        sqe_mask,
    input logic        pin_active
);
    // R4
    od_never_high_chk: assert property (@(posedge clk) disable iff (!hrst_n)
        !rd_data[14] |-> !led_o);

    // R5
    pol1_follow_chk: assert property (@(posedge clk) disable iff (!hrst_n)
        (rd_data[14] && !rd_data[13]) |-> (led_oe && led_o == pin_active));

    // R6
    dis_pol0_float_chk: assert property (@(posedge clk) disable iff (!hrst_n)
        (rd_data[13] && !rd_data[14]) |-> !led_oe);

    // R6
    dis_pol1_low_chk: assert property (@(posedge clk) disable iff (!hrst_n)
        (rd_data[13] && rd_data[14]) |-> (led_oe && !led_o));

    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!hrst_n)
        (rd_data[31:16] == 16'h0) && (rd_data[12:10] == 3'b000));

    // R12
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!hrst_n)
        !wr_en |=> $stable(rd_data[14:0]));

    // R10
    sqe_open_chk: assert property (@(posedge clk) disable iff (!hrst_n)
        (tx_done && srst_n && !stop) |=> sqe_mask);

    // R8
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!hrst_n)
        (rd_data[15] && rd_data[7] && srst_n && !stop && !wr_en) |=> pin_active);
endmodule

bind led_status_drv led_status_chk u_chk (
    .clk        (clk),
    .hrst_n     (hrst_n),
    .srst_n     (srst_n),
    .stop       (stop),
    .wr_en      (wr_en),
    .tx_done    (tx_done),
    .rd_data    (rd_data),
    .led_o      (led_o),
    .led_oe     (led_oe),
    .sqe_mask   (sqe_mask),
    .pin_active (pin_active)
);

// File: tb/tb_led_status_drv.sv
module tb_led_status_drv;
    localparam int CLK_PERIOD = 10;
    localparam int STR_N      = 6;
    localparam int MHZ        = 2;
    localparam int WIN        = MHZ * 4;

    logic        clk = 1'b0;
    logic        hrst_n = 1'b0, srst_n = 1'b1, stop = 1'b0, wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [6:0]  ev_in = '0;
    logic        tx_done = 1'b0, link_pass = 1'b0, fdx_on = 1'b0;
    logic        mp_mode = 1'b0, mp_hit = 1'b0;
    logic        led_o, led_oe;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic        q_led[$];
    logic        q_oe[$];
    logic [31:0] q_rd[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    led_status_drv #(.CLK_MHZ(MHZ), .SQE_US(4), .STRETCH_CYC(STR_N)) dut (
        .clk(clk), .hrst_n(hrst_n), .srst_n(srst_n), .stop(stop),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ev_in(ev_in), .tx_done(tx_done), .link_pass(link_pass),
        .fdx_on(fdx_on), .mp_mode(mp_mode), .mp_hit(mp_hit),
        .led_o(led_o), .led_oe(led_oe)
    );

    task automatic expect_now(input logic el, input logic eo,
                              input logic [31:0] er, input string tag);
        q_led.push_back(el);
        q_oe.push_back(eo);
        q_rd.push_back(er);
        q_tag.push_back(tag);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        settle();
    endtask

    // monitor: pops each expectation and compares against the ports
    initial begin
        forever begin
            wait (q_tag.size() != 0);
            #1;
            begin
                logic el, eo;
                logic [31:0] er;
                string t;
                el = q_led.pop_front();
                eo = q_oe.pop_front();
                er = q_rd.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (led_o !== el || led_oe !== eo || rd_data !== er) begin
                    errors++;
                    $display("FAIL %s: got led=%b oe=%b rd=%h, expected led=%b oe=%b rd=%h",
                             t, led_o, led_oe, rd_data, el, eo, er);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        hrst_n = 1'b1;
        settle();
        expect_now(0, 0, 32'h0000_0090, "R1 reset default");

        // R2 R4: transmit activity, open drain pulls low
        @(negedge clk); ev_in[4] = 1'b1; settle();
        expect_now(0, 1, 32'h0000_8090, "R4 R2 active low");
        // R8: stretch for STR_N cycles, R7 status already low
        @(negedge clk); ev_in[4] = 1'b0; settle();
        expect_now(0, 1, 32'h0000_0090, "R8 R7 held cycle 1");
        for (int i = 2; i <= STR_N; i++) begin
            @(negedge clk); settle();
            expect_now(0, 1, 32'h0000_0090, "R8 held");
        end
        @(negedge clk); settle();
        expect_now(0, 0, 32'h0000_0090, "R8 released");

        // R5 R9
        wr(32'h0000_4001);
        expect_now(0, 1, 32'h0000_4001, "R5 idle driven low");
        @(negedge clk); ev_in[0] = 1'b1; settle();
        expect_now(1, 1, 32'h0000_C001, "R5 active high");
        @(negedge clk); ev_in[0] = 1'b0; settle();
        expect_now(0, 1, 32'h0000_4001, "R9 no stretch");
        @(negedge clk); ev_in[4] = 1'b1; settle();
        expect_now(0, 1, 32'h0000_4001, "R2 disabled input ignored");
        @(negedge clk); ev_in[4] = 1'b0;

        // R6 R7
        ev_in[0] = 1'b1;
        wr(32'h0000_6001);
        expect_now(0, 1, 32'h0000_E001, "R6 R7 pol1 disabled low");
        wr(32'h0000_2001);
        expect_now(0, 0, 32'h0000_A001, "R6 R7 pol0 disabled float");
        @(negedge clk); ev_in[0] = 1'b0;

        // R11
        wr(32'hFFFF_FFFF);
        expect_now(0, 1, 32'h0000_63FF, "R11 reserved ignored");

        // R3
        wr(32'h0000_4100);
        @(negedge clk); link_pass = 1'b1; settle();
        expect_now(0, 1, 32'h0000_4100, "R3 link without fdx");
        @(negedge clk); fdx_on = 1'b1; settle();
        expect_now(1, 1, 32'h0000_C100, "R3 link fdx");
        @(negedge clk); link_pass = 1'b0; fdx_on = 1'b0;
        wr(32'h0000_4200);
        @(negedge clk); mp_hit = 1'b1; settle();
        expect_now(0, 1, 32'h0000_4200, "R3 magic without mode");
        @(negedge clk); mp_mode = 1'b1; settle();
        expect_now(1, 1, 32'h0000_C200, "R3 magic in mode");
        @(negedge clk); mp_hit = 1'b0; mp_mode = 1'b0;

        // R10
        wr(32'h0000_4001);
        @(negedge clk); tx_done = 1'b1; ev_in[0] = 1'b1; settle();
        expect_now(0, 1, 32'h0000_4001, "R10 strobe cycle");
        @(negedge clk); tx_done = 1'b0; settle();
        expect_now(0, 1, 32'h0000_4001, "R10 window start");
        for (int i = 2; i <= WIN; i++) begin
            @(negedge clk); settle();
            if (i == WIN) expect_now(0, 1, 32'h0000_4001, "R10 window last");
        end
        @(negedge clk); settle();
        expect_now(1, 1, 32'h0000_C001, "R10 window over");
        @(negedge clk); ev_in[0] = 1'b0;

        // R12: stop and soft reset
        wr(32'h0000_4090);
        @(negedge clk); ev_in[4] = 1'b1; settle();
        expect_now(1, 1, 32'h0000_C090, "R12 setup");
        @(negedge clk); ev_in[4] = 1'b0; stop = 1'b1; settle();
        expect_now(1, 1, 32'h0000_4090, "R12 held before stop edge");
        @(negedge clk); stop = 1'b0; settle();
        expect_now(0, 1, 32'h0000_4090, "R12 stop clears stretch keeps ctrl");
        @(negedge clk); ev_in[4] = 1'b1; settle();
        @(negedge clk); ev_in[4] = 1'b0; srst_n = 1'b0; settle();
        expect_now(1, 1, 32'h0000_4090, "R12 held before soft reset edge");
        @(negedge clk); srst_n = 1'b1; settle();
        expect_now(0, 1, 32'h0000_4090, "R12 soft reset keeps ctrl");

        // R1 hard reset
        @(negedge clk); hrst_n = 1'b0; settle();
        expect_now(0, 0, 32'h0000_0090, "R1 hard reset clears");
        @(negedge clk); hrst_n = 1'b1;

        wait (q_tag.size() == 0);
        #2;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule